// File: doc/BRIEF.md
# Wiper and Setting Register Controller

This block keeps the digital state of a 1024-position digital potentiometer. It holds one volatile 10-bit wiper register and four 10-bit setting registers that stand in for non-volatile storage. A host drives a command port: each accepted command is a one-cycle strobe carrying an opcode, a register index and write data. Through it the host can load the wiper directly, read either kind of register, write any setting register, or copy a value between any setting register and the wiper in either direction.

The wiper value is decoded into a one-hot tap select. Two flags mark the end terminals. Any command that changes a setting register starts a slow storage write. The length of that write is a parameter in clock cycles. While it runs, a busy bit stays high, and further commands that would change a setting register are dropped with a one-cycle error pulse.

There are two resets. The power-on reset sets every setting register to a default value and sets the wiper to that same value. The soft reset leaves the setting registers alone and reloads only the wiper from setting register 0.

Top module: `wiper_setting_ctrl`

## Requirements
- R1: While `porRstN` is low, and after it is released, every setting register holds `SET_DEFAULT` (default 0x155) and `wiperPos` equals `SET_DEFAULT`. `busy`, `rdValid` and `cmdErr` are 0.
- R2: Opcode 0 (load wiper) with `cmdValid` high makes `wiperPos` equal `cmdWrData` in the cycle after the command.
- R3: Opcode 1 (read wiper) and opcode 3 (read setting `cmdIdx`) raise `rdValid` for exactly the one cycle after the command. In that cycle `rdData` holds the register value as it was when the command was given.
- R4: Opcode 2 (write setting) stores `cmdWrData` into setting register `cmdIdx` and starts a slow write. `busy` reads 1 in the cycle after the command.
- R5: `busy` stays high for exactly `BUSY_CYCLES` consecutive cycles (default 8) after each accepted setting-register change, and is 0 at all other times.
- R6: While `busy` is 1, opcodes 2 and 5 change no setting register and raise `cmdErr` for exactly one cycle. Opcodes 0, 1, 3 and 4 are still carried out.
- R7: Opcode 4 copies setting register `cmdIdx` into the wiper, which is visible on `wiperPos` the next cycle.
- R8: Opcode 5 copies the wiper into setting register `cmdIdx` and starts a slow write, just as opcode 2 does.
- R9: When `softRstN` is low at a clock edge, the wiper reloads from setting register 0, any command in that cycle is ignored, and all setting registers keep their contents.
- R10: `tapSel` has exactly one bit set, at index `wiperPos`. `atLow` is 1 only when `wiperPos` is 0x000. `atHigh` is 1 only when `wiperPos` is 0x3FF.
- R11: Opcodes 6 and 7 change no register and raise neither `cmdErr` nor `rdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous active-low power-on reset |
| softRstN | input | 1 | Synchronous active-low wiper reload from setting 0 |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Opcode (0 load wiper, 1 read wiper, 2 write setting, 3 read setting, 4 setting to wiper, 5 wiper to setting) |
| cmdIdx | input | 2 | Setting register index |
| cmdWrData | input | 10 | Write data |
| rdData | output | 10 | Read data |
| rdValid | output | 1 | Read data valid, one cycle after a read command |
| cmdErr | output | 1 | One-cycle pulse when a setting change is refused |
| busy | output | 1 | Slow setting write in progress |
| wiperPos | output | 10 | Current wiper value |
| tapSel | output | 1024 | One-hot tap select |
| atLow | output | 1 | Wiper at low terminal |
| atHigh | output | 1 | Wiper at high terminal |

## Verification
The hardest case to reach is a command that arrives while a slow write is still running. The host usually waits for `busy` to fall, so this case only happens when commands are issued back to back. The stimulus table has a per-entry flag that skips the wait for idle. This lets rejected writes, reads and wiper loads all land inside the busy window. Later reads then show at the ports that the refused writes left the setting registers unchanged. Separate directed tests measure the busy length edge by edge and check that a soft reset keeps the stored settings.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_WIPER   = 3'd0,
    OP_READ_WIPER   = 3'd1,
    OP_WRITE_SET    = 3'd2,
    OP_READ_SET     = 3'd3,
    OP_SET_TO_WIPER = 3'd4,
    OP_WIPER_TO_SET = 3'd5
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWiper;
    logic wiperFromSet;
    logic storeSet;
    logic setFromWiper;
    logic readReq;
    logic readSet;
    logic reload;
  } ctrlStrobe_t;

endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        softRstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        cmdErr
);

  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES + 1) : 1;

  logic             accept;
  logic             isSetMod;
  logic             startWrite;
  logic [CNT_W-1:0] busyCnt;

  assign accept     = cmdValid && softRstN;
  assign isSetMod   = (cmdOp == OP_WRITE_SET) || (cmdOp == OP_WIPER_TO_SET);
  assign startWrite = accept && isSetMod && !busy;

  always_comb begin
    strobe              = '0;
    strobe.reload       = !softRstN;
    strobe.loadWiper    = accept && ((cmdOp == OP_LOAD_WIPER) || (cmdOp == OP_SET_TO_WIPER));
    strobe.wiperFromSet = (cmdOp == OP_SET_TO_WIPER);
    strobe.storeSet     = startWrite;
    strobe.setFromWiper = (cmdOp == OP_WIPER_TO_SET);
    strobe.readReq      = accept && ((cmdOp == OP_READ_WIPER) || (cmdOp == OP_READ_SET));
    strobe.readSet      = (cmdOp == OP_READ_SET);
  end

  // slow storage write timer
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      busy    <= 1'b0;
      busyCnt <= '0;
      cmdErr  <= 1'b0;
    end else begin
      cmdErr <= accept && isSetMod && busy;
      if (startWrite) begin
        busy    <= 1'b1;
        busyCnt <= CNT_W'(BUSY_CYCLES - 1);
      end else if (busy) begin
        if (busyCnt == '0) begin
          busy <= 1'b0;
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter int WIPER_W     = 10,
  parameter int SET_NUM     = 4,
  parameter int SET_DEFAULT = 'h155
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  ctrlStrobe_t                strobe,
  input  logic [$clog2(SET_NUM)-1:0] cmdIdx,
  input  logic [WIPER_W-1:0]         cmdWrData,
  output logic [WIPER_W-1:0]         wiperPos,
  output logic [WIPER_W-1:0]         rdData,
  output logic                       rdValid,
  output logic [(1<<WIPER_W)-1:0]    tapSel,
  output logic                       atLow,
  output logic                       atHigh
);

  localparam int TAPS = 1 << WIPER_W;

  logic [WIPER_W-1:0] setReg [SET_NUM];
  logic [WIPER_W-1:0] wiper;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      for (int s = 0; s < SET_NUM; s++) begin
        setReg[s] <= WIPER_W'(SET_DEFAULT);
      end
      wiper   <= WIPER_W'(SET_DEFAULT);
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.reload) begin
        wiper <= setReg[0];
      end else if (strobe.loadWiper) begin
        wiper <= strobe.wiperFromSet ? setReg[cmdIdx] : cmdWrData;
      end
      if (strobe.storeSet) begin
        setReg[cmdIdx] <= strobe.setFromWiper ? wiper : cmdWrData;
      end
      rdValid <= strobe.readReq;
      if (strobe.readReq) begin
        rdData <= strobe.readSet ? setReg[cmdIdx] : wiper;
      end
    end
  end

  assign wiperPos = wiper;

  // one comparator per tap
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tapSel[t] = (wiper == WIPER_W'(t));
  end

  assign atLow  = (wiper == '0);
  assign atHigh = (wiper == '1);

endmodule

// File: rtl/wiper_setting_ctrl.sv
module wiper_setting_ctrl
  import wiper_pkg::*;
#(
  parameter int WIPER_W     = 10,
  parameter int SET_NUM     = 4,
  parameter int SET_DEFAULT = 'h155,
  parameter int BUSY_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       softRstN,
  input  logic                       cmdValid,
  input  logic [2:0]                 cmdOp,
  input  logic [$clog2(SET_NUM)-1:0] cmdIdx,
  input  logic [WIPER_W-1:0]         cmdWrData,
  output logic [WIPER_W-1:0]         rdData,
  output logic                       rdValid,
  output logic                       cmdErr,
  output logic                       busy,
  output logic [WIPER_W-1:0]         wiperPos,
  output logic [(1<<WIPER_W)-1:0]    tapSel,
  output logic                       atLow,
  output logic                       atHigh
);

  ctrlStrobe_t strobe;

  wiper_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .porRstN (porRstN),
    .softRstN(softRstN),
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .strobe  (strobe),
    .busy    (busy),
    .cmdErr  (cmdErr)
  );

  wiper_datapath #(
    .WIPER_W    (WIPER_W),
    .SET_NUM    (SET_NUM),
    .SET_DEFAULT(SET_DEFAULT)
  ) i_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .strobe   (strobe),
    .cmdIdx   (cmdIdx),
    .cmdWrData(cmdWrData),
    .wiperPos (wiperPos),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .tapSel   (tapSel),
    .atLow    (atLow),
    .atHigh   (atHigh)
  );

endmodule

// File: rtl/wiper_setting_ctrl_chk.sv
module wiper_setting_ctrl_chk #(
  parameter int WIPER_W = 10,
  parameter int SET_NUM = 4
) (
  input logic                       clk,
  input logic                       porRstN,
  input logic                       softRstN,
  input logic                       cmdValid,
  input logic [2:0]                 cmdOp,
  input logic [$clog2(SET_NUM)-1:0] cmdIdx,
  input logic [WIPER_W-1:0]         cmdWrData,
  input logic [WIPER_W-1:0]         rdData,
  input logic                       rdValid,
  input logic                       cmdErr,
  input logic                       busy,
  input logic [WIPER_W-1:0]         wiperPos,
  input logic [(1<<WIPER_W)-1:0]    tapSel,
  input logic                       atLow,
  input logic                       atHigh
);

  logic unusedIdx;
  assign unusedIdx = ^cmdIdx;

  // R2
  load_wiper_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (cmdValid && softRstN && cmdOp == 3'd0) |=> (wiperPos == $past(cmdWrData)));

  // R3
  read_wiper_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (cmdValid && softRstN && cmdOp == 3'd1) |=> (rdValid && rdData == $past(wiperPos)));

  // R4
  write_busy_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (cmdValid && softRstN && cmdOp == 3'd2) |=> busy);

  // R6
  refuse_err_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (cmdValid && softRstN && busy && (cmdOp == 3'd2 || cmdOp == 3'd5)) |=> cmdErr);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cmdErr |-> $past(busy));

  // R10
  onehot_chk: assert property (@(posedge clk) disable iff (!porRstN)
    ($countones(tapSel) == 1) && tapSel[wiperPos]);

  // R10
  ends_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (atLow == tapSel[0]) && (atHigh == tapSel[(1<<WIPER_W)-1]));

  // R11
  spare_op_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (cmdValid && cmdOp[2:1] == 2'b11) |=> (!cmdErr && !rdValid && $stable(wiperPos)));

endmodule

bind wiper_setting_ctrl wiper_setting_ctrl_chk #(
  .WIPER_W(WIPER_W),
  .SET_NUM(SET_NUM)
) i_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .softRstN (softRstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdIdx   (cmdIdx),
  .cmdWrData(cmdWrData),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .cmdErr   (cmdErr),
  .busy     (busy),
  .wiperPos (wiperPos),
  .tapSel   (tapSel),
  .atLow    (atLow),
  .atHigh   (atHigh)
);

// File: tb/test_wiper_setting_ctrl.sv
module test_wiper_setting_ctrl;

  localparam int W    = 10;
  localparam int BUSY = 8;
  localparam int DEF  = 'h155;

  logic          clk = 1'b0;
  logic          porRstN = 1'b0;
  logic          softRstN = 1'b1;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [1:0]    cmdIdx = '0;
  logic [W-1:0]  cmdWrData = '0;
  logic [W-1:0]  rdData;
  logic          rdValid;
  logic          cmdErr;
  logic          busy;
  logic [W-1:0]  wiperPos;
  logic [1023:0] tapSel;
  logic          atLow;
  logic          atHigh;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  wiper_setting_ctrl #(
    .WIPER_W(W), .SET_NUM(4), .SET_DEFAULT(DEF), .BUSY_CYCLES(BUSY)
  ) i_wiper_setting_ctrl (
    .clk(clk), .porRstN(porRstN), .softRstN(softRstN), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdIdx(cmdIdx), .cmdWrData(cmdWrData), .rdData(rdData),
    .rdValid(rdValid), .cmdErr(cmdErr), .busy(busy), .wiperPos(wiperPos),
    .tapSel(tapSel), .atLow(atLow), .atHigh(atHigh)
  );

  typedef struct packed {
    logic [2:0]   op;
    logic [1:0]   idx;
    logic [W-1:0] data;
    logic [W-1:0] expWiper;
    logic         expRd;
    logic [W-1:0] expRdData;
    logic         expErr;
    logic         noWait;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 10'h2A0, 10'h2A0, 1'b0, 10'h000, 1'b0, 1'b0}, // R2 load
    '{3'd1, 2'd0, 10'h000, 10'h2A0, 1'b1, 10'h2A0, 1'b0, 1'b0}, // R3 read wiper
    '{3'd2, 2'd2, 10'h0F0, 10'h2A0, 1'b0, 10'h000, 1'b0, 1'b0}, // R4 write set2
    '{3'd2, 2'd1, 10'h111, 10'h2A0, 1'b0, 10'h000, 1'b1, 1'b1}, // R6 refused
    '{3'd3, 2'd2, 10'h000, 10'h2A0, 1'b1, 10'h0F0, 1'b0, 1'b1}, // R6 read ok while busy
    '{3'd5, 2'd3, 10'h000, 10'h2A0, 1'b0, 10'h000, 1'b1, 1'b1}, // R6 refused copy
    '{3'd0, 2'd0, 10'h3FF, 10'h3FF, 1'b0, 10'h000, 1'b0, 1'b1}, // R6 load ok while busy
    '{3'd3, 2'd1, 10'h000, 10'h3FF, 1'b1, 10'h155, 1'b0, 1'b0}, // R6 set1 untouched
    '{3'd3, 2'd3, 10'h000, 10'h3FF, 1'b1, 10'h155, 1'b0, 1'b0}, // R6 set3 untouched
    '{3'd4, 2'd2, 10'h000, 10'h0F0, 1'b0, 10'h000, 1'b0, 1'b0}, // R7 set2 to wiper
    '{3'd5, 2'd0, 10'h000, 10'h0F0, 1'b0, 10'h000, 1'b0, 1'b0}, // R8 wiper to set0
    '{3'd3, 2'd0, 10'h000, 10'h0F0, 1'b1, 10'h0F0, 1'b0, 1'b0}, // R8 read set0
    '{3'd6, 2'd0, 10'h000, 10'h0F0, 1'b0, 10'h000, 1'b0, 1'b0}, // R11 spare op
    '{3'd0, 2'd0, 10'h000, 10'h000, 1'b0, 10'h000, 1'b0, 1'b0}  // R10 low end
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkTaps(input string req, input logic [W-1:0] expPos);
    logic [1023:0] expTap;
    expTap = '0;
    expTap[expPos] = 1'b1;
    nChecks++;
    if (tapSel !== expTap) begin
      nFails++;
      $display("FAIL %s tapSel: actual bit count %0d expected one-hot at %0h",
               req, $countones(tapSel), expPos);
    end
    check(req, "atLow", 32'(atLow), 32'(expPos == 0));
    check(req, "atHigh", 32'(atHigh), 32'(expPos == 10'h3FF));
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] idx,
                       input logic [W-1:0] data);
    cmdOp = op; cmdIdx = idx; cmdWrData = data; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "wiper in reset", 32'(wiperPos), DEF);
    porRstN = 1'b1;
    @(negedge clk);
    check("R1", "wiper", 32'(wiperPos), DEF);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "rdValid", 32'(rdValid), 0);
    check("R1", "cmdErr", 32'(cmdErr), 0);

    for (int v = 0; v < NV; v++) begin
      if (!VECS[v].noWait) waitIdle();
      issue(VECS[v].op, VECS[v].idx, VECS[v].data);
      check("R2/R6/R7/R8/R11", $sformatf("vec %0d wiper", v), 32'(wiperPos), 32'(VECS[v].expWiper));
      check("R3/R11", $sformatf("vec %0d rdValid", v), 32'(rdValid), 32'(VECS[v].expRd));
      if (VECS[v].expRd)
        check("R3", $sformatf("vec %0d rdData", v), 32'(rdData), 32'(VECS[v].expRdData));
      check("R6/R11", $sformatf("vec %0d cmdErr", v), 32'(cmdErr), 32'(VECS[v].expErr));
      checkTaps("R10", VECS[v].expWiper);
    end

    // R3 / R6 pulses last a single cycle
    waitIdle();
    issue(3'd1, 2'd0, 10'h0);
    @(negedge clk);
    check("R3", "rdValid falls", 32'(rdValid), 0);
    issue(3'd2, 2'd1, 10'h222);
    issue(3'd2, 2'd3, 10'h333);
    check("R6", "err pulse", 32'(cmdErr), 1);
    @(negedge clk);
    check("R6", "err falls", 32'(cmdErr), 0);

    // R5 busy length
    waitIdle();
    issue(3'd2, 2'd1, 10'h222);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    check("R5", "busy cycles", 32'(cnt), BUSY);

    // R10 high end
    issue(3'd0, 2'd0, 10'h3FF);
    checkTaps("R10", 10'h3FF);

    // R9 soft reset: wiper from set0 (0F0), settings kept
    softRstN = 1'b0;
    issue(3'd0, 2'd0, 10'h001);
    softRstN = 1'b1;
    check("R9", "wiper reload", 32'(wiperPos), 'h0F0);
    issue(3'd3, 2'd1, 10'h0);
    check("R9", "set1 kept", 32'(rdData), 'h222);
    issue(3'd3, 2'd3, 10'h0);
    check("R9", "set3 kept", 32'(rdData), 'h155);

    // R1 power-on reset restores defaults
    porRstN = 1'b0;
    @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    check("R1", "wiper after por", 32'(wiperPos), DEF);
    issue(3'd3, 2'd1, 10'h0);
    check("R1", "set1 default", 32'(rdData), DEF);
    issue(3'd3, 2'd0, 10'h0);
    check("R1", "set0 default", 32'(rdData), DEF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule